// File: doc/BRIEF.md
# Bundled-Data Handshake Link Stage

This block is a clocked model of one stage of a single-rail handshake link. A data word arrives together with a request line. The stage stores the word in one register and answers on an acknowledge line. It then presents the word downstream. Before it raises its own request, it waits a run-time number of clock cycles, so the word has settled before the request can be seen. Both sides of the stage carry a request/acknowledge pair, so stages chain directly to form a longer link.

A build parameter selects the signalling style:

- **Return-to-zero four-phase.** The request rises, the acknowledge rises, the request falls and the acknowledge falls. Only after that may the next word start.
- **Transition-based two-phase.** Any edge of the request, rising or falling, announces a word. Any edge of the acknowledge accepts it.

When no word is offered, no line in the stage moves.

Top module: `bd_link_stage`

## Requirements
- R1: While `rst` is high and in the cycle after it, `up_ack` and `dn_req` are 0 in both modes. The two-phase parity of each side is therefore even.
- R2: The downstream request event appears exactly M+1 clock cycles after the cycle in which the upstream acknowledge event for that word appears. M is the value of `margin` (`margin` is a run-time input that sets the settling delay, sampled one cycle after capture).
- R3: A `margin` of 0 is treated as 1. The downstream request then comes 2 cycles after the acknowledge.
- R4: Four-phase mode, empty stage: `up_ack` rises one cycle after `up_req` is seen high. `up_ack` falls one cycle after `up_req` is seen low.
- R5: Four-phase mode: `dn_req` falls one cycle after `dn_ack` is seen high. `dn_req` does not rise again while `dn_ack` stays high.
- R6: Two-phase mode: each change of `up_req` on an empty stage is captured. It produces exactly one change of `up_ack`, after which `up_ack` equals `up_req`. `up_ack` does not return to zero.
- R7: Two-phase mode: `dn_req` changes exactly once per word. The word is retired when `dn_ack` equals `dn_req`.
- R8: `dn_data` equals the captured word. It stays unchanged from capture until that word is retired.
- R9: The stage holds one word. While it is occupied, a new upstream request is not acknowledged until the held word is retired downstream.
- R10: With no upstream request pending and the stage empty, neither `dn_req` nor `up_ack` changes.
- R11: A chain of three stages under random stalls at both ends delivers every word in order. No word is lost or duplicated.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| margin | input | MARGIN_W | Settling delay in cycles before the downstream request |
| up_req | input | 1 | Request from the sender |
| up_data | input | DATA_W | Word from the sender |
| up_ack | output | 1 | Acknowledge to the sender |
| dn_req | output | 1 | Request to the receiver |
| dn_data | output | DATA_W | Stored word toward the receiver |
| dn_ack | input | 1 | Acknowledge from the receiver |

## Verification
The assertions take for granted that the sender holds `up_data` steady and makes no new request event until the current one is acknowledged. In four-phase mode they also assume the sender does not raise `up_req` again while `up_ack` is still high. They assume the receiver only moves `dn_ack` in reply to a request event, and that `margin` changes only while the stage is empty. The bench drivers change data only after the acknowledge event is observed. They follow each protocol phase in order. The bench changes `margin` only after every sent word has been retired downstream.

// File: rtl/bd_link_pkg.sv
package bd_link_pkg;
  typedef enum logic [1:0] {
    TX_IDLE,
    TX_WAIT,
    TX_REQ,
    TX_RELEASE
  } tx_state_e;
endpackage

// File: rtl/bd_margin_timer.sv
module bd_margin_timer #(
  parameter int CNT_W = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [CNT_W-1:0] margin,
  output logic             expired
);
  logic [CNT_W-1:0] cnt;
  logic             busy;

  // zero is clamped to one: both load a count of zero
  always_ff @(posedge clk) begin
    if (rst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (start) begin
      busy <= 1'b1;
      cnt  <= (margin == '0) ? '0 : margin - 1'b1;
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  assign expired = busy && (cnt == '0);

  assert_start_when_free_R2: assert property (@(posedge clk) disable iff (rst)
    start |-> !busy);
  assert_run_begins_on_start_R3: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> $past(start));
endmodule

// File: rtl/bd_rx_capture.sv
module bd_rx_capture #(
  parameter int DATA_W     = 16,
  parameter bit FOUR_PHASE = 1'b1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              up_req,
  input  logic [DATA_W-1:0] up_data,
  input  logic              retire,
  output logic              up_ack,
  output logic              full,
  output logic [DATA_W-1:0] data_q
);
  logic accept;

  generate
    if (FOUR_PHASE) begin : g_rz
      assign accept = !full && up_req && !up_ack;
    end else begin : g_tr
      assign accept = !full && (up_req != up_ack);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      up_ack <= 1'b0;
      full   <= 1'b0;
      data_q <= '0;
    end else begin
      if (accept) begin
        data_q <= up_data;
        full   <= 1'b1;
        up_ack <= FOUR_PHASE ? 1'b1 : ~up_ack;
      end else begin
        if (retire) full <= 1'b0;
        if (FOUR_PHASE && up_ack && !up_req) up_ack <= 1'b0;
      end
    end
  end

  assert_word_held_R8: assert property (@(posedge clk) disable iff (rst)
    full && $past(full) |-> $stable(data_q));
  assert_retire_only_full_R9: assert property (@(posedge clk) disable iff (rst)
    retire |-> full);

  generate
    if (FOUR_PHASE) begin : g_chk_rz
      assert_ack_rise_R4: assert property (@(posedge clk) disable iff (rst)
        $rose(up_ack) |-> $past(up_req) && !$past(full));
      assert_ack_fall_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(up_ack) |-> !$past(up_req));
    end else begin : g_chk_tr
      assert_ack_edge_R6: assert property (@(posedge clk) disable iff (rst)
        (up_ack != $past(up_ack)) |-> !$past(full) && ($past(up_req) != $past(up_ack)));
    end
  endgenerate
endmodule

// File: rtl/bd_tx_launch.sv
module bd_tx_launch
  import bd_link_pkg::*;
#(
  parameter bit FOUR_PHASE = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic full,
  input  logic expired,
  input  logic dn_ack,
  output logic start,
  output logic done,
  output logic dn_req
);
  tx_state_e state;

  assign start = full && (state == TX_IDLE);

  generate
    if (FOUR_PHASE) begin : g_done_rz
      assign done = (state == TX_RELEASE) && !dn_ack;
    end else begin : g_done_tr
      assign done = (state == TX_REQ) && (dn_ack == dn_req);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      state  <= TX_IDLE;
      dn_req <= 1'b0;
    end else begin
      case (state)
        TX_IDLE: if (full) state <= TX_WAIT;
        TX_WAIT: if (expired) begin
          dn_req <= FOUR_PHASE ? 1'b1 : ~dn_req;
          state  <= TX_REQ;
        end
        TX_REQ: begin
          if (FOUR_PHASE) begin
            if (dn_ack) begin
              dn_req <= 1'b0;
              state  <= TX_RELEASE;
            end
          end else if (dn_ack == dn_req) begin
            state <= TX_IDLE;
          end
        end
        TX_RELEASE: if (!dn_ack) state <= TX_IDLE;
        default: state <= TX_IDLE;
      endcase
    end
  end

  assert_quiet_when_empty_R10: assert property (@(posedge clk) disable iff (rst)
    !full |-> $stable(dn_req));

  generate
    if (FOUR_PHASE) begin : g_chk_rz
      assert_req_after_margin_R2: assert property (@(posedge clk) disable iff (rst)
        $rose(dn_req) |-> $past(expired));
      assert_req_drop_on_ack_R5: assert property (@(posedge clk) disable iff (rst)
        $fell(dn_req) |-> $past(dn_ack));
    end else begin : g_chk_tr
      assert_req_edge_after_margin_R7: assert property (@(posedge clk) disable iff (rst)
        (dn_req != $past(dn_req)) |-> $past(expired));
    end
  endgenerate
endmodule

// File: rtl/bd_link_stage.sv
module bd_link_stage #(
  parameter int DATA_W     = 16,
  parameter int MARGIN_W   = 4,
  parameter bit FOUR_PHASE = 1'b1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [MARGIN_W-1:0] margin,
  input  logic                up_req,
  input  logic [DATA_W-1:0]   up_data,
  output logic                up_ack,
  output logic                dn_req,
  output logic [DATA_W-1:0]   dn_data,
  input  logic                dn_ack
);
  logic full, retire, start, expired;

  bd_rx_capture #(.DATA_W(DATA_W), .FOUR_PHASE(FOUR_PHASE)) u_rx (
    .clk(clk), .rst(rst), .up_req(up_req), .up_data(up_data),
    .retire(retire), .up_ack(up_ack), .full(full), .data_q(dn_data)
  );

  bd_margin_timer #(.CNT_W(MARGIN_W)) u_timer (
    .clk(clk), .rst(rst), .start(start), .margin(margin), .expired(expired)
  );

  bd_tx_launch #(.FOUR_PHASE(FOUR_PHASE)) u_tx (
    .clk(clk), .rst(rst), .full(full), .expired(expired), .dn_ack(dn_ack),
    .start(start), .done(retire), .dn_req(dn_req)
  );

  assert_retire_frees_R9: assert property (@(posedge clk) disable iff (rst)
    retire |=> !full);
  assert_launch_needs_word_R8: assert property (@(posedge clk) disable iff (rst)
    expired |-> full);
endmodule

// File: tb/bd_link_stage_bench.sv
module bd_link_stage_bench;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int errors = 0;
  int checks = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // single four-phase stage
  logic [3:0]  s_margin = 4'd3;
  logic        s_up_req = 1'b0, s_dn_ack = 1'b0;
  logic [15:0] s_up_data = '0;
  logic        s_up_ack, s_dn_req;
  logic [15:0] s_dn_data;

  bd_link_stage #(.DATA_W(16), .MARGIN_W(4), .FOUR_PHASE(1'b1)) u_bd_link_stage (
    .clk(clk), .rst(rst), .margin(s_margin), .up_req(s_up_req), .up_data(s_up_data),
    .up_ack(s_up_ack), .dn_req(s_dn_req), .dn_data(s_dn_data), .dn_ack(s_dn_ack)
  );

  // two-phase chain of three
  logic [3:0]  c_margin = 4'd2;
  logic        c_req0 = 1'b0, c_ack3 = 1'b0;
  logic [15:0] c_data0 = '0;
  logic        c_ack0, c_ack1, c_ack2, c_req1, c_req2, c_req3;
  logic [15:0] c_data1, c_data2, c_data3;

  bd_link_stage #(.DATA_W(16), .MARGIN_W(4), .FOUR_PHASE(1'b0)) u_chain0 (
    .clk(clk), .rst(rst), .margin(c_margin), .up_req(c_req0), .up_data(c_data0),
    .up_ack(c_ack0), .dn_req(c_req1), .dn_data(c_data1), .dn_ack(c_ack1));
  bd_link_stage #(.DATA_W(16), .MARGIN_W(4), .FOUR_PHASE(1'b0)) u_chain1 (
    .clk(clk), .rst(rst), .margin(c_margin), .up_req(c_req1), .up_data(c_data1),
    .up_ack(c_ack1), .dn_req(c_req2), .dn_data(c_data2), .dn_ack(c_ack2));
  bd_link_stage #(.DATA_W(16), .MARGIN_W(4), .FOUR_PHASE(1'b0)) u_chain2 (
    .clk(clk), .rst(rst), .margin(c_margin), .up_req(c_req2), .up_data(c_data2),
    .up_ack(c_ack2), .dn_req(c_req3), .dn_data(c_data3), .dn_ack(c_ack3));

  logic [15:0] exp4[$];
  int          cap_q[$];
  int          lat_q[$];
  int          sent4 = 0, retired4 = 0;
  bit          hold_ack = 1'b0;
  int          stall4 = 0;
  logic [15:0] expc[$];
  int          recvc = 0;
  localparam int CHAIN_WORDS = 40;

  task automatic send4(input logic [15:0] w, output int waited);
    @(negedge clk);
    s_up_data = w;
    s_up_req  = 1'b1;
    exp4.push_back(w);
    sent4++;
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (!s_up_ack && waited < 2000);
    cap_q.push_back(cyc);
    lat_q.push_back(((s_margin == 4'd0) ? 1 : int'(s_margin)) + 1);
    s_up_req = 1'b0;
    @(negedge clk);
    chk(s_up_ack == 1'b0, "R4 ack falls one cycle after req low", 32'(s_up_ack), 0);
  endtask

  // downstream responder for the single stage
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && s_dn_req && !s_dn_ack) begin
        if (exp4.size() == 0) begin
          chk(1'b0, "R10 request with nothing sent", 1, 0);
        end else begin
          logic [15:0] w;
          int c, l;
          w = exp4.pop_front();
          c = cap_q.pop_front();
          l = lat_q.pop_front();
          chk(s_dn_data == w, "R8 data toward receiver", 32'(s_dn_data), 32'(w));
          if (l == 2) chk(cyc - c == l, "R3 zero margin acts as one", cyc - c, l);
          else        chk(cyc - c == l, "R2 request delay", cyc - c, l);
          for (int k = 0; k < stall4; k++) begin
            @(negedge clk);
            chk(s_dn_req && s_dn_data == w, "R8 word held while waiting", 32'(s_dn_data), 32'(w));
          end
          while (hold_ack) @(negedge clk);
        end
        s_dn_ack = 1'b1;
        @(negedge clk);
        chk(s_dn_req == 1'b0, "R5 req drops after ack", 32'(s_dn_req), 0);
        for (int k = 0; k < 2; k++) begin
          @(negedge clk);
          chk(s_dn_req == 1'b0, "R5 no new req while ack high", 32'(s_dn_req), 0);
        end
        s_dn_ack = 1'b0;
        retired4++;
      end
    end
  end

  // downstream responder for the chain
  initial begin
    forever begin
      @(negedge clk);
      if (!rst && c_req3 != c_ack3) begin
        if (expc.size() == 0) begin
          chk(1'b0, "R11 duplicate word", 32'(c_data3), 0);
        end else begin
          logic [15:0] w;
          w = expc.pop_front();
          chk(c_data3 == w, "R11 in-order delivery", 32'(c_data3), 32'(w));
        end
        repeat ($urandom_range(0, 4)) @(negedge clk);
        c_ack3 = c_req3;
        recvc++;
        @(negedge clk);
        chk(c_req3 == c_ack3, "R7 one request edge per word", 32'(c_req3), 32'(c_ack3));
      end
    end
  end

  task automatic send2(input logic [15:0] w, output int waited);
    @(negedge clk);
    c_data0 = w;
    c_req0  = ~c_req0;
    expc.push_back(w);
    waited = 0;
    do begin
      @(negedge clk);
      waited++;
    end while (c_ack0 != c_req0 && waited < 2000);
    @(negedge clk);
    chk(c_ack0 == c_req0, "R6 ack stays on new level", 32'(c_ack0), 32'(c_req0));
  endtask

  task automatic run_single();
    int n;
    s_margin = 4'd3;
    stall4 = 0;
    send4(16'hA001, n);
    chk(n == 1, "R4 ack one cycle after req", n, 1);
    stall4 = 2;
    send4(16'h5A5A, n);
    send4(16'hFFFF, n);
    stall4 = 0;
    send4(16'h0000, n);
    while (retired4 != sent4) @(negedge clk);
    s_margin = 4'd0;
    send4(16'h1234, n);
    send4(16'h4321, n);
    while (retired4 != sent4) @(negedge clk);
    s_margin = 4'd5;
    hold_ack = 1'b1;
    send4(16'hB001, n);
    @(negedge clk);
    s_up_data = 16'hB002;
    s_up_req  = 1'b1;
    for (int k = 0; k < 12; k++) begin
      @(negedge clk);
      chk(s_up_ack == 1'b0, "R9 no ack while stage occupied", 32'(s_up_ack), 0);
    end
    hold_ack = 1'b0;
    send4(16'hB002, n);
    while (retired4 != sent4) @(negedge clk);
  endtask

  task automatic run_chain();
    int n;
    for (int i = 0; i < CHAIN_WORDS; i++) begin
      send2(16'(i * 97 + 13), n);
      if (i == 0) chk(n == 1, "R6 capture one cycle after req edge", n, 1);
      repeat ($urandom_range(0, 3)) @(negedge clk);
    end
    while (recvc < CHAIN_WORDS) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(s_up_ack == 1'b0 && s_dn_req == 1'b0, "R1 four-phase reset lines", {s_up_ack, s_dn_req}, 0);
    chk(c_ack0 == 1'b0 && c_req3 == 1'b0, "R1 two-phase reset parity", {c_ack0, c_req3}, 0);
    rst = 1'b0;
    @(negedge clk);
    chk(s_up_ack == 1'b0 && s_dn_req == 1'b0, "R1 lines low after reset", {s_up_ack, s_dn_req}, 0);
    fork
      run_single();
      run_chain();
    join
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      chk(s_dn_req == 1'b0 && s_up_ack == 1'b0 && c_req3 == c_ack3 && c_ack0 == c_req0,
          "R10 idle link stays quiet", {s_dn_req, s_up_ack}, 0);
    end
    chk(expc.size() == 0 && recvc == CHAIN_WORDS, "R11 none lost", recvc, CHAIN_WORDS);
    chk(exp4.size() == 0 && retired4 == sent4, "R8 all single-stage words delivered", retired4, sent4);
    if (!finished) begin
      finished = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule